// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer that links two unrelated clock domains. A producer writes words on its own clock, and a consumer reads them in the same order on a second clock. The word width defaults to 9 bits. The depth is a power-of-two parameter between 256 and 8192 words. Each side uses a pair of enable inputs, and an access happens only when both are high. This lets two separate control sources gate the port without any external logic.

Four active-low status flags report the fill level. The full and almost-full flags are registered on the write clock. The empty and almost-empty flags are registered on the read clock. The two programmable flags compare the fill level against offsets that can be loaded. After reset both offsets are 7. Offsets are written on the write clock through a small register port, and a load is accepted only while the FIFO is empty. Pointers pass between the domains as Gray codes through a chain of synchronizer flops. Because of this, a change caused by the opposite port reaches a flag a few clocks late.

Top module: `pflag_async_fifo`

## Requirements
- R1: While `rst_n` is low and after it rises, `empty_n` and `aempty_n` are 0 and `full_n` and `afull_n` are 1 until the first write.
- R2: Words leave through `rd_data` in exactly the order in which they were accepted on the write side, with no loss or duplication.
- R3: A write takes place on a rising `wr_clk` edge only when `wr_en_a` and `wr_en_b` are both 1 and `full_n` is 1. If only one write enable is high, nothing is stored.
- R4: A read takes place on a rising `rd_clk` edge only when `rd_en_a` and `rd_en_b` are both 1 and `empty_n` is 1. If only one read enable is high, nothing is removed.
- R5: `full_n` is 0 when DEPTH words are held. Writes attempted while it is 0 are discarded, so exactly DEPTH words can be read back.
- R6: `empty_n` is 0 when no word is held. A read attempted while it is 0 leaves `rd_data` and the stored contents unchanged.
- R7: With almost-full offset m, once both clocks have settled, `afull_n` is 0 at DEPTH−m or more words and 1 at DEPTH−m−1 or fewer words.
- R8: With almost-empty offset n, once both clocks have settled, `aempty_n` is 0 at n or fewer words and 1 at n+1 or more words.
- R9: Reset sets both the almost-full offset m and the almost-empty offset n to 7.
- R10: When `cfg_we` is 1 on a `wr_clk` edge, `cfg_offset` is loaded into n if `cfg_sel` is 0, or into m if `cfg_sel` is 1. The load happens only while the write side sees the FIFO as empty. At any other time the request is ignored.
- R11: `rd_data` is a register. It changes on the `rd_clk` edge that performs a read and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | DATA_W | Word to store |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_data | output | DATA_W | Registered output word |
| full_n | output | 1 | Low when the FIFO holds DEPTH words |
| afull_n | output | 1 | Low at DEPTH−m or more words |
| empty_n | output | 1 | Low when the FIFO holds no words |
| aempty_n | output | 1 | Low at n or fewer words |
| cfg_we | input | 1 | Offset load strobe (write clock) |
| cfg_sel | input | 1 | 0 selects n (almost-empty), 1 selects m (almost-full) |
| cfg_offset | input | log2(DEPTH) | Offset value to load |

## Verification
The hardest conditions to reach are the exact one-word boundaries of the programmable flags and the full state. Each flag reacts to the other domain only after the synchronizer delay, so its value is meaningful only once both clocks have gone quiet. The stimulus therefore fills the FIFO to exactly one word below and then exactly at each threshold, lets both clocks idle, and samples the flag at each step. Offset loads are tried once while the FIFO is empty and once while it holds data. In the second case the fill level is chosen so that an accepted load would visibly flip the almost-empty flag.

// File: rtl/pff_pkg.sv
package pff_pkg;

   localparam int OFS_DEFAULT = 7;

   typedef enum logic {
      SEL_EMPTY_OFS = 1'b0,
      SEL_FULL_OFS  = 1'b1
   } ofs_sel_e;

   function automatic logic depth_ok(input int d);
      return (d == 256) || (d == 512) || (d == 1024) ||
             (d == 2048) || (d == 4096) || (d == 8192);
   endfunction

endpackage

// File: rtl/pff_gray_sync.sv
module pff_gray_sync #(
   parameter int W      = 9,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_in,
   output logic [W-1:0] bin_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pff_gray_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= '0;
      end else begin
         stg_q[0] <= gray_in;
         for (int s = 1; s < STAGES; s++) begin
            stg_q[s] <= stg_q[s-1];
         end
      end
   end

   // Gray to binary: each bit is the parity of all higher gray bits
   for (genvar b = 0; b < W; b++) begin : g_g2b
      assign bin_out[b] = ^stg_q[STAGES-1][W-1:b];
   end

endmodule

// File: rtl/pff_store.sv
module pff_store #(
   parameter int DATA_W = 9,
   parameter int ADDR_W = 8
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [WORDS];

   always_ff @(posedge wr_clk) begin
      if (we) mem_q[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem_q[raddr];
   end

   // R11
   rdata_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !re |=> $stable(rdata));

endmodule

// File: rtl/pff_wr_ctl.sv
module pff_wr_ctl #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_a,
   input  logic              en_b,
   input  logic [ADDR_W:0]   rbin_sync,
   input  logic [ADDR_W-1:0] ofs_full,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W:0]   wgray,
   output logic              full_n,
   output logic              afull_n,
   output logic              is_empty
);

   localparam int              PTR_W   = ADDR_W + 1;
   localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1 << ADDR_W);

   logic [PTR_W-1:0] wbin_q, wbin_nx, cnt_now, cnt_nx, afull_thr;

   assign we        = en_a & en_b & full_n;
   assign wbin_nx   = wbin_q + PTR_W'(we);
   assign cnt_now   = wbin_q - rbin_sync;
   assign cnt_nx    = wbin_nx - rbin_sync;
   assign afull_thr = DEPTH_P - {1'b0, ofs_full};
   assign is_empty  = (cnt_now == '0);
   assign waddr     = wbin_q[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray   <= '0;
         full_n  <= 1'b1;
         afull_n <= 1'b1;
      end else begin
         wbin_q  <= wbin_nx;
         wgray   <= wbin_nx ^ (wbin_nx >> 1);
         full_n  <= (cnt_nx != DEPTH_P);
         afull_n <= (cnt_nx < afull_thr);
      end
   end

   // R3
   wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_a && en_b) |=> $stable(wbin_q));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_now <= DEPTH_P);

   // R7
   afull_with_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !afull_n);

   // R2
   wgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray)));

endmodule

// File: rtl/pff_rd_ctl.sv
module pff_rd_ctl #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_a,
   input  logic              en_b,
   input  logic [ADDR_W:0]   wbin_sync,
   input  logic [ADDR_W-1:0] ofs_empty,
   output logic              re,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rgray,
   output logic              empty_n,
   output logic              aempty_n
);

   localparam int PTR_W = ADDR_W + 1;

   logic [PTR_W-1:0] rbin_q, rbin_nx, cnt_nx;

   assign re      = en_a & en_b & empty_n;
   assign rbin_nx = rbin_q + PTR_W'(re);
   assign cnt_nx  = wbin_sync - rbin_nx;
   assign raddr   = rbin_q[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q   <= '0;
         rgray    <= '0;
         empty_n  <= 1'b0;
         aempty_n <= 1'b0;
      end else begin
         rbin_q   <= rbin_nx;
         rgray    <= rbin_nx ^ (rbin_nx >> 1);
         empty_n  <= (cnt_nx != '0);
         aempty_n <= (cnt_nx > {1'b0, ofs_empty});
      end
   end

   // R4
   rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(en_a && en_b) |=> $stable(rbin_q));

   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |=> $stable(rbin_q));

   // R8
   aempty_with_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> !aempty_n);

   // R2
   rgray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rgray ^ $past(rgray)));

endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo #(
   parameter  int DATA_W      = 9,
   parameter  int DEPTH       = 256,
   parameter  int SYNC_STAGES = 2,
   localparam int ADDR_W      = $clog2(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_en_a,
   input  logic              wr_en_b,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en_a,
   input  logic              rd_en_b,
   output logic [DATA_W-1:0] rd_data,
   output logic              full_n,
   output logic              afull_n,
   output logic              empty_n,
   output logic              aempty_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_offset
);

   import pff_pkg::*;

   localparam int PTR_W = ADDR_W + 1;

   if (!depth_ok(DEPTH)) begin : g_bad_depth
      $error("pflag_async_fifo: DEPTH must be a power of two from 256 to 8192");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("pflag_async_fifo: DATA_W must be positive");
   end

   logic              wr_go, rd_go, wr_is_empty;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PTR_W-1:0]  wgray, rgray, wbin_in_rd, rbin_in_wr;
   logic [ADDR_W-1:0] ofs_full_q, ofs_empty_q;

   // Offsets: reset to the default, reloadable only while the write side sees no data
   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_full_q  <= ADDR_W'(OFS_DEFAULT);
         ofs_empty_q <= ADDR_W'(OFS_DEFAULT);
      end else if (cfg_we && wr_is_empty) begin
         if (ofs_sel_e'(cfg_sel) == SEL_FULL_OFS) ofs_full_q  <= cfg_offset;
         else                                     ofs_empty_q <= cfg_offset;
      end
   end

   pff_wr_ctl #(.ADDR_W(ADDR_W)) u_wr_ctl (
      .clk       (wr_clk),
      .rst_n     (rst_n),
      .en_a      (wr_en_a),
      .en_b      (wr_en_b),
      .rbin_sync (rbin_in_wr),
      .ofs_full  (ofs_full_q),
      .we        (wr_go),
      .waddr     (waddr),
      .wgray     (wgray),
      .full_n    (full_n),
      .afull_n   (afull_n),
      .is_empty  (wr_is_empty)
   );

   pff_rd_ctl #(.ADDR_W(ADDR_W)) u_rd_ctl (
      .clk       (rd_clk),
      .rst_n     (rst_n),
      .en_a      (rd_en_a),
      .en_b      (rd_en_b),
      .wbin_sync (wbin_in_rd),
      .ofs_empty (ofs_empty_q),
      .re        (rd_go),
      .raddr     (raddr),
      .rgray     (rgray),
      .empty_n   (empty_n),
      .aempty_n  (aempty_n)
   );

   pff_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r_sync (
      .clk     (rd_clk),
      .rst_n   (rst_n),
      .gray_in (wgray),
      .bin_out (wbin_in_rd)
   );

   pff_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w_sync (
      .clk     (wr_clk),
      .rst_n   (rst_n),
      .gray_in (rgray),
      .bin_out (rbin_in_wr)
   );

   pff_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .wr_clk (wr_clk),
      .we     (wr_go),
      .waddr  (waddr),
      .wdata  (wr_data),
      .rd_clk (rd_clk),
      .rst_n  (rst_n),
      .re     (rd_go),
      .raddr  (raddr),
      .rdata  (rd_data)
   );

   // R10
   cfg_locked_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !wr_is_empty |=> ($stable(ofs_full_q) && $stable(ofs_empty_q)));

endmodule

// File: tb/pflag_async_fifo_bench.sv
module pflag_async_fifo_bench;

   localparam int DATA_W = 9;
   localparam int DEPTH  = 256;
   localparam int AW     = 8;

   logic              wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic              wr_en_a = 1'b0, wr_en_b = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_en_a = 1'b0, rd_en_b = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              full_n, afull_n, empty_n, aempty_n;
   logic              cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [AW-1:0]     cfg_offset = '0;

   int errs = 0, checks = 0, pop_cnt = 0, seq = 1;
   logic [DATA_W-1:0] exp_q[$];

   always #5 wr_clk = ~wr_clk;   // 100 MHz write clock
   always #7 rd_clk = ~rd_clk;

   pflag_async_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pflag_async_fifo (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
      .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_data(rd_data),
      .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_offset(cfg_offset)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   // Driver: one write-clock cycle; a word is expected only if the write is accepted
   task automatic wr_cyc(input bit a, input bit b, input logic [DATA_W-1:0] d);
      @(posedge wr_clk); #2;
      wr_en_a = a; wr_en_b = b; wr_data = d;
      if (a && b && full_n) exp_q.push_back(d);
   endtask

   task automatic rd_cyc(input bit a, input bit b);
      @(posedge rd_clk); #2;
      rd_en_a = a; rd_en_b = b;
   endtask

   task automatic settle();
      repeat (10) @(posedge rd_clk);
      repeat (6) @(posedge wr_clk);
      #3;
   endtask

   task automatic fill_to(input int k);
      while (exp_q.size() < k) begin
         wr_cyc(1'b1, 1'b1, DATA_W'(seq));
         seq++;
      end
      wr_cyc(1'b0, 1'b0, '0);
      settle();
   endtask

   task automatic drain();
      while (exp_q.size() > 0) rd_cyc(1'b1, 1'b1);
      rd_cyc(1'b0, 1'b0);
      settle();
   endtask

   task automatic cfg_load(input bit sel, input logic [AW-1:0] v);
      @(posedge wr_clk); #2;
      cfg_we = 1'b1; cfg_sel = sel; cfg_offset = v;
      @(posedge wr_clk); #2;
      cfg_we = 1'b0;
   endtask

   // Monitor: scoreboard compare (R2, R11) and hold check on idle or empty reads (R6, R11)
   bit                fire_pend = 1'b0;
   logic [DATA_W-1:0] last_data = '0;
   always @(negedge rd_clk) begin
      if (!rst_n) begin
         fire_pend = 1'b0;
      end else begin
         if (fire_pend) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected word", int'(rd_data), -1);
            end else begin
               logic [DATA_W-1:0] e;
               e = exp_q.pop_front();
               pop_cnt++;
               chk(rd_data === e, "R2/R11 read data", int'(rd_data), int'(e));
            end
         end else begin
            chk(rd_data === last_data, "R6/R11 rd_data hold", int'(rd_data), int'(last_data));
         end
         fire_pend = rd_en_a && rd_en_b && empty_n;
      end
      last_data = rd_data;
   end

   initial begin
      repeat (150000) @(posedge wr_clk);
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
      $finish;
   end

   initial begin
      repeat (4) @(posedge wr_clk);
      #1;
      // R1: flags during reset
      chk(empty_n == 1'b0 && aempty_n == 1'b0, "R1 empty flags in reset", {empty_n, aempty_n}, 0);
      chk(full_n == 1'b1 && afull_n == 1'b1, "R1 full flags in reset", {full_n, afull_n}, 3);
      @(negedge wr_clk); rst_n = 1'b1;
      settle();
      chk(empty_n == 1'b0 && aempty_n == 1'b0 && full_n && afull_n, "R1 flags after reset",
          {empty_n, aempty_n, full_n, afull_n}, 3);

      // R3: a single write enable stores nothing
      for (int i = 0; i < 3; i++) begin
         wr_cyc(1'b1, 1'b0, 9'h1AA);
         wr_cyc(1'b0, 1'b1, 9'h155);
      end
      wr_cyc(1'b0, 1'b0, '0);
      settle();
      chk(empty_n == 1'b0, "R3 single enable write ignored", empty_n, 0);

      // R8 / R9: default n = 7
      fill_to(7);
      chk(empty_n == 1'b1, "R6 not empty at 7 words", empty_n, 1);
      chk(aempty_n == 1'b0, "R8/R9 aempty low at n words", aempty_n, 0);
      fill_to(8);
      chk(aempty_n == 1'b1, "R8/R9 aempty high at n+1 words", aempty_n, 1);

      // R4: a single read enable removes nothing (one read would drop to 7 words)
      for (int i = 0; i < 3; i++) begin
         rd_cyc(1'b1, 1'b0);
         rd_cyc(1'b0, 1'b1);
      end
      rd_cyc(1'b0, 1'b0);
      settle();
      chk(aempty_n == 1'b1, "R4 single enable read ignored", aempty_n, 1);

      // R7 / R9: default m = 7
      fill_to(DEPTH - 8);
      chk(afull_n == 1'b1, "R7/R9 afull high at DEPTH-m-1", afull_n, 1);
      fill_to(DEPTH - 7);
      chk(afull_n == 1'b0, "R7/R9 afull low at DEPTH-m", afull_n, 0);
      chk(full_n == 1'b1, "R5 not full below DEPTH", full_n, 1);

      // R5: full, then extra writes are discarded
      fill_to(DEPTH);
      chk(full_n == 1'b0, "R5 full at DEPTH words", full_n, 0);
      for (int i = 0; i < 4; i++) wr_cyc(1'b1, 1'b1, 9'h0F0);
      wr_cyc(1'b0, 1'b0, '0);
      settle();
      chk(full_n == 1'b0, "R5 still full after extra writes", full_n, 0);
      pop_cnt = 0;
      drain();
      chk(pop_cnt == DEPTH, "R5 words read after full", pop_cnt, DEPTH);
      chk(empty_n == 1'b0 && aempty_n == 1'b0, "R6 empty after drain", {empty_n, aempty_n}, 0);
      chk(full_n == 1'b1 && afull_n == 1'b1, "R7 not full after drain", {full_n, afull_n}, 3);

      // R6: reads on empty do nothing (monitor checks rd_data hold)
      for (int i = 0; i < 4; i++) rd_cyc(1'b1, 1'b1);
      rd_cyc(1'b0, 1'b0);
      settle();
      chk(empty_n == 1'b0, "R6 empty stays low after empty reads", empty_n, 0);

      // R10: load n = 3 and m = 250 while empty
      cfg_load(1'b0, 8'd3);
      cfg_load(1'b1, 8'd250);
      fill_to(3);
      chk(aempty_n == 1'b0, "R10/R8 aempty low at loaded n", aempty_n, 0);
      fill_to(4);
      chk(aempty_n == 1'b1, "R10/R8 aempty high at loaded n+1", aempty_n, 1);
      fill_to(5);
      chk(afull_n == 1'b1, "R10/R7 afull high at DEPTH-m-1", afull_n, 1);
      fill_to(6);
      chk(afull_n == 1'b0, "R10/R7 afull low at DEPTH-m", afull_n, 0);

      // R10: load while non-empty is ignored (n = 10 would pull aempty low at 6 words)
      cfg_load(1'b0, 8'd10);
      settle();
      chk(aempty_n == 1'b1, "R10 load ignored while not empty", aempty_n, 1);
      drain();
      chk(exp_q.size() == 0, "R2 all words returned", exp_q.size(), 0);

      report();
      $finish;
   end

endmodule